// File: doc/BRIEF.md
# Instruction Fetch Unit with Return-Address Stack

This block is the front end of a small processor with 8-bit instruction addresses. It keeps the program counter and reads a 256-word by 32-bit instruction store. The read path from address to word is combinational. The word at the current program counter, together with that address, is presented to the decode stage in every cycle. A load port fills the store with a program. Reset clears every word to zero, which is the no-operation opcode.

The execute stage steers fetch with three inputs: a jump request with a target address, a 2-bit stack command, and the address of the instruction that issued the command. A taken call-style branch asserts the jump request and the push command at once. The target is then loaded and the return address is saved on an 8-entry hardware stack. A return issues the pop command, and fetch resumes at the address on top of the stack. With no redirect, the counter advances by one each clock.

Top module: `ifetch_ras`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `fe_pc` is 0, `fe_instr` is 0, and both `ras_ovf` and `ras_udf` are 0.
- R2: With `ex_jump` low and `ex_stack_op` not equal to 01, `fe_pc` increases by one at each rising clock edge, wrapping from 255 to 0.
- R3: `fe_instr` always equals the stored word at address `fe_pc`, in the same cycle. Asserting `ld_we` writes `ld_data` to address `ld_addr` at the next rising edge.
- R4: Reset clears every word of the instruction store to zero.
- R5: With `ex_jump` high and `ex_stack_op` not equal to 01, `fe_pc` takes the value of `ex_target` at the next edge.
- R6: Stack command 10 (push) saves `ex_inst_pc + 1`. Command 01 (pop) loads `fe_pc` with the most recently saved value still on the stack, in last-in first-out order.
- R7: A pop takes priority over a simultaneous jump request and over the increment.
- R8: The stack holds 8 entries. A push while 8 are held overwrites the top entry and sets `ras_ovf`, which stays set until reset.
- R9: A pop on an empty stack loads `fe_pc` with 0 and sets `ras_udf`, which stays set until reset.
- R10: Stack command 00 and the unused command 11 leave the stack untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Instruction store write enable |
| ld_addr | input | 8 | Instruction store write address |
| ld_data | input | 32 | Instruction store write word |
| ex_jump | input | 1 | Jump request from execute |
| ex_target | input | 8 | Jump target address |
| ex_stack_op | input | 2 | Stack command: 00 none, 01 pop, 10 push, 11 none |
| ex_inst_pc | input | 8 | Address of the instruction issuing the stack command |
| fe_instr | output | 32 | Word fetched at `fe_pc` |
| fe_pc | output | 8 | Current program counter |
| ras_ovf | output | 1 | Sticky stack overflow flag |
| ras_udf | output | 1 | Sticky stack underflow flag |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a jump request and a push arrive together. The bench checks that the counter takes the target and that a later pop returns the issuing address plus one. In the second, a jump request arrives with a pop. The bench pushes a known return address first, then drives both inputs at once, and expects the popped address and not the jump target. The overflow and underflow boundaries are reached by nine pushes from empty and by a pop on a freshly reset stack. The values that come out of the following pops show which entry was overwritten.

// File: rtl/ifetch_pkg.sv
`timescale 1ns/1ps
// Package ifetch_pkg: shared widths and the stack command encoding used by
// the fetch unit. Assumes 8-bit instruction addresses and 32-bit words.
package ifetch_pkg;
    localparam int unsigned AW       = 8;
    localparam int unsigned DW       = 32;
    localparam int unsigned RAS_SLOTS = 8;

    typedef enum logic [1:0] {
        RAS_NONE  = 2'b00,
        RAS_POP   = 2'b01,
        RAS_PUSH  = 2'b10,
        RAS_SPARE = 2'b11
    } ras_op_e;
endpackage

// File: rtl/ifu_imem.sv
`timescale 1ns/1ps
// Module ifu_imem: instruction store with a combinational read port and a
// synchronous load port. Assumes reset may take one cycle to clear all words.
module ifu_imem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Clear every word on reset, otherwise accept one load per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read toward decode.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ifu_ret_stack.sv
`timescale 1ns/1ps
// Module ifu_ret_stack: return-address stack. A push when full overwrites the
// top slot; a pop when empty yields address 0. Both conditions set sticky
// flags. Assumes push and pop never occur in the same cycle.
module ifu_ret_stack #(
    parameter int unsigned AW    = 8,
    parameter int unsigned SLOTS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val,
    output logic [$clog2(SLOTS+1)-1:0] fill,
    output logic          ovf,
    output logic          udf
);
    localparam int unsigned PW = $clog2(SLOTS);
    localparam int unsigned CW = $clog2(SLOTS+1);

    logic [AW-1:0] slot [SLOTS];
    logic [CW-1:0] cnt;
    logic          full, empty;
    logic [PW-1:0] wr_idx, top_idx;

    // Pointer arithmetic for the write slot and the current top.
    always_comb begin
        full    = (cnt == CW'(SLOTS));
        empty   = (cnt == '0);
        top_idx = PW'(cnt - CW'(1));
        wr_idx  = full ? PW'(SLOTS-1) : PW'(cnt);
    end

    // Occupancy and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            udf <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + CW'(1);
        end else if (pop) begin
            if (empty) udf <= 1'b1;
            else       cnt <= cnt - CW'(1);
        end
    end

    // Slot storage, written only on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
        end else if (push) begin
            slot[wr_idx] <= push_val;
        end
    end

    assign top_val = empty ? '0 : slot[top_idx];
    assign fill    = cnt;
endmodule

// File: rtl/ifu_pc_reg.sv
`timescale 1ns/1ps
// Module ifu_pc_reg: program counter with redirect selection. Priority:
// pop, then jump, then increment. Assumes all requests are synchronous.
module ifu_pc_reg #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic [AW-1:0] pop_addr,
    input  logic          jump_req,
    input  logic [AW-1:0] jump_addr,
    output logic [AW-1:0] pc
);
    logic [AW-1:0] pc_nxt;

    // Select the next fetch address.
    always_comb begin
        if (pop_req)       pc_nxt = pop_addr;
        else if (jump_req) pc_nxt = jump_addr;
        else               pc_nxt = pc + AW'(1);
    end

    // Hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_nxt;
    end
endmodule

// File: rtl/ifetch_ras.sv
`timescale 1ns/1ps
// Module ifetch_ras: fetch front end. Joins the PC register, the instruction
// store and the return stack. Assumes execute raises the jump and push
// together for a taken call-style branch.
module ifetch_ras
    import ifetch_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [7:0]    ld_addr,
    input  logic [31:0]   ld_data,
    input  logic          ex_jump,
    input  logic [7:0]    ex_target,
    input  logic [1:0]    ex_stack_op,
    input  logic [7:0]    ex_inst_pc,
    output logic [31:0]   fe_instr,
    output logic [7:0]    fe_pc,
    output logic          ras_ovf,
    output logic          ras_udf
);
    localparam int unsigned CW = $clog2(RAS_SLOTS+1);

    ras_op_e        op;
    logic           do_push, do_pop;
    logic [AW-1:0]  ret_addr, top_addr;
    logic [CW-1:0]  ras_fill;

    // Decode the stack command.
    always_comb begin
        op       = ras_op_e'(ex_stack_op);
        do_push  = (op == RAS_PUSH);
        do_pop   = (op == RAS_POP);
        ret_addr = ex_inst_pc + AW'(1);
    end

    ifu_pc_reg #(.AW(AW)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (do_pop),
        .pop_addr  (top_addr),
        .jump_req  (ex_jump),
        .jump_addr (ex_target),
        .pc        (fe_pc)
    );

    ifu_imem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (fe_pc),
        .rdata (fe_instr)
    );

    ifu_ret_stack #(.AW(AW), .SLOTS(RAS_SLOTS)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (ret_addr),
        .top_val  (top_addr),
        .fill     (ras_fill),
        .ovf      (ras_ovf),
        .udf      (ras_udf)
    );
endmodule

// File: rtl/ifetch_ras_chk.sv
`timescale 1ns/1ps
// Module ifetch_ras_chk: temporal checks on the fetch unit's ports and its
// stack occupancy. Attached to ifetch_ras by the bind below.
module ifetch_ras_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ex_jump,
    input logic [7:0] ex_target,
    input logic [1:0] ex_stack_op,
    input logic [7:0] fe_pc,
    input logic [3:0] ras_fill,
    input logic       ras_ovf,
    input logic       ras_udf
);
    // R2
    seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_jump && ex_stack_op != 2'b01) |=> fe_pc == $past(fe_pc) + 8'd1);

    // R5
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_jump && ex_stack_op != 2'b01) |=> fe_pc == $past(ex_target));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_stack_op == 2'b01 && ras_fill == 4'd0) |=> (fe_pc == 8'd0 && ras_udf));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_ovf |=> ras_ovf);

    // R9
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_udf |=> ras_udf);

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fill <= 4'd8);

    // R10
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_stack_op == 2'b00 || ex_stack_op == 2'b11) |=> $stable(ras_fill));
endmodule

bind ifetch_ras ifetch_ras_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_jump     (ex_jump),
    .ex_target   (ex_target),
    .ex_stack_op (ex_stack_op),
    .fe_pc       (fe_pc),
    .ras_fill    (ras_fill),
    .ras_ovf     (ras_ovf),
    .ras_udf     (ras_udf)
);

// File: tb/tb_ifetch_ras.sv
`timescale 1ns/1ps
// Bench tb_ifetch_ras: directed scenarios, one task each. Inputs change and
// outputs are sampled on the falling edge.
module tb_ifetch_ras;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        ex_jump = 1'b0;
    logic [7:0]  ex_target = '0;
    logic [1:0]  ex_stack_op = 2'b00;
    logic [7:0]  ex_inst_pc = '0;
    logic [31:0] fe_instr;
    logic [7:0]  fe_pc;
    logic        ras_ovf, ras_udf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ifetch_ras dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .ex_jump(ex_jump), .ex_target(ex_target), .ex_stack_op(ex_stack_op),
        .ex_inst_pc(ex_inst_pc), .fe_instr(fe_instr), .fe_pc(fe_pc),
        .ras_ovf(ras_ovf), .ras_udf(ras_udf)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge with the given controls, then idle controls.
    task automatic step(input logic j, input logic [7:0] tgt, input logic [1:0] op, input logic [7:0] ipc);
        ex_jump = j; ex_target = tgt; ex_stack_op = op; ex_inst_pc = ipc;
        @(negedge clk);
        ex_jump = 1'b0; ex_stack_op = 2'b00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ex_jump = 1'b0; ex_stack_op = 2'b00; ld_we = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", fe_pc, 0);
        check("R1 instr", fe_instr, 0);
        check("R1 ovf", ras_ovf, 0);
        check("R1 udf", ras_udf, 0);
    endtask

    task automatic t_load_read();
        for (int i = 0; i < 5; i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = 32'hC0DE_0000 + i;
            @(negedge clk);
        end
        ld_we = 1'b0;
        step(1'b1, 8'd2, 2'b00, 8'd0);
        check("R5 jump to 2", fe_pc, 8'd2);
        check("R3 word 2", fe_instr, 32'hC0DE_0002);
        step(1'b0, 8'd0, 2'b00, 8'd0);
        check("R2 next pc", fe_pc, 8'd3);
        check("R3 word 3", fe_instr, 32'hC0DE_0003);
        ld_we = 1'b1; ld_addr = 8'd4; ld_data = 32'h1234_5678;
        @(negedge clk);
        ld_we = 1'b0;
        check("R3 same-cycle read of new word", fe_instr, 32'h1234_5678);
    endtask

    task automatic t_wrap();
        step(1'b1, 8'd254, 2'b00, 8'd0);
        step(1'b0, 8'd0, 2'b00, 8'd0);
        check("R2 at 255", fe_pc, 8'd255);
        step(1'b0, 8'd0, 2'b00, 8'd0);
        check("R2 wrap to 0", fe_pc, 8'd0);
    endtask

    task automatic t_call_return();
        step(1'b1, 8'd10, 2'b10, 8'd40);
        check("R6 call target", fe_pc, 8'd10);
        step(1'b0, 8'd0, 2'b00, 8'd0);
        step(1'b1, 8'd20, 2'b10, 8'd50);
        check("R6 nested call target", fe_pc, 8'd20);
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R6 inner return", fe_pc, 8'd51);
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R6 outer return", fe_pc, 8'd41);
        check("R6 no underflow", ras_udf, 0);
    endtask

    task automatic t_priority();
        step(1'b0, 8'd0, 2'b10, 8'd70);
        step(1'b1, 8'd99, 2'b01, 8'd0);
        check("R7 pop over jump", fe_pc, 8'd71);
    endtask

    task automatic t_ignored_op();
        step(1'b0, 8'd0, 2'b10, 8'd30);
        step(1'b0, 8'd0, 2'b11, 8'd5);
        step(1'b0, 8'd0, 2'b00, 8'd6);
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R10 spare/none leave stack", fe_pc, 8'd31);
        check("R10 stack not emptied early", ras_udf, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R9 empty pop pc", fe_pc, 8'd0);
        check("R9 udf set", ras_udf, 1);
        step(1'b0, 8'd0, 2'b00, 8'd0);
        check("R9 udf sticky", ras_udf, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b0, 8'd0, 2'b10, 8'(i));
        check("R8 no ovf at 8", ras_ovf, 0);
        step(1'b0, 8'd0, 2'b10, 8'd8);
        check("R8 ovf set", ras_ovf, 1);
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R8 top overwritten", fe_pc, 8'd9);
        step(1'b0, 8'd0, 2'b01, 8'd0);
        check("R8 next entry intact", fe_pc, 8'd7);
        check("R8 ovf sticky", ras_ovf, 1);
    endtask

    task automatic t_reset_clears();
        ld_we = 1'b1; ld_addr = 8'd2; ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ld_we = 1'b0;
        do_reset();
        step(1'b1, 8'd2, 2'b00, 8'd0);
        check("R4 cleared word", fe_instr, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_read();
        t_wrap();
        t_call_return();
        t_priority();
        t_ignored_op();
        t_underflow();
        t_overflow();
        t_reset_clears();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule